// File: doc/BRIEF.md
# Dot-Product Accelerator Register Wrapper

This block is the slave side of a small dot-product engine that a processor drives over a simple memory-mapped bus. Software stores a length N in an argument register and then writes 1 to a status register. The engine then steps an index through two external word memories. Each cycle it adds A[i]*B[i] into a 32-bit accumulator. A read of the data register returns the sum. If the engine is still running, the read is held off with a wait signal until the result is final, so software needs no polling loop: one write of the argument, one write of start, one read.

The two operand memories sit outside the block. The engine presents one index on both memory address outputs and takes the addressed words back in the same cycle. The status register reports a busy flag and a done flag. A start written while the engine runs changes nothing.

Top module: `dotp_accel_wrap`

## Requirements
- R1: Byte offsets decode as follows: 0x0 is the result (data), 0x8 is status, and 0xC is the argument N. A read of any other offset returns 0, and a write to it has no effect.
- R2: A write to offset 0xC stores the 32-bit argument, and a read of 0xC returns it.
- R3: Writing the value 1 to offset 0x8 while idle starts a run. The next read of status shows busy=1 and done=0, so a new start clears done. Writing any other value to 0x8 starts nothing.
- R4: The result is the sum of A[i]*B[i] for i = 0 to N-1, computed modulo 2^32 from the low 32 bits of each product.
- R5: A run keeps busy at 1 for N+1 cycles. After that, status reads busy=0 and done=1, with busy in bit 0 and done in bit 1.
- R6: A read of offset 0x0 while busy holds waitrequest_o at 1 until the run ends. It then completes with the final result.
- R7: A write of 1 to status while busy is ignored. The running sum, the busy length and the final result stay those of the first start.
- R8: With N = 0, busy lasts one cycle and the result is 0.
- R9: After reset, status reads 0, data reads 0, the argument reads 0 and waitrequest_o is 0.
- R10: During a run, both memory address outputs carry the current index. The index starts at 0 on the first busy cycle and rises by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte offset within the accelerator |
| write_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| read_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data |
| waitrequest_o | output | 1 | Holds off the current read while a result is pending |
| a_addr_o | output | 8 | Index into operand memory A |
| a_rdata_i | input | 32 | Word of A at a_addr_o |
| b_addr_o | output | 8 | Index into operand memory B |
| b_rdata_i | input | 32 | Word of B at b_addr_o |

## Verification
Random lengths from 1 to 40 over random full-range operands exercise the accumulation and its modulo-2^32 wrap. The same runs count the stall length of the data read, which separates a correct N+1-cycle busy window from an off-by-one in the stop test. Directed cases cover three things. N = 0 and N = 1 probe the stop condition at its edges. All-ones operands force a wrap on every product. A restart while busy, with a different argument, shows whether the length is latched at start or read live. Status writes of values other than 1 and accesses to an unmapped offset confirm that the decode ignores them.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int BUS_AW = 4;
  localparam logic [BUS_AW-1:0] OFS_DATA = 4'h0;
  localparam logic [BUS_AW-1:0] OFS_STAT = 4'h8;
  localparam logic [BUS_AW-1:0] OFS_ARG  = 4'hC;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_DONE_BIT = 1;
endpackage

// File: rtl/dotp_regs.sv
module dotp_regs
  import dotp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              write_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              read_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DW-1:0]     result_i,
  output logic [DW-1:0]     arg_o,
  output logic              start_o,
  output logic [DW-1:0]     rdata_o,
  output logic              waitrequest_o
);
  logic [DW-1:0] arg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         arg_q <= '0;
    else if (write_i && addr_i == OFS_ARG) arg_q <= wdata_i;
  end

  // start only on an exact value of 1 and only when idle
  assign start_o = write_i && (addr_i == OFS_STAT) && (wdata_i == DW'(1)) && !busy_i;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_DATA: rdata_o = result_i;
      OFS_STAT: begin
        rdata_o[STAT_BUSY_BIT] = busy_i;
        rdata_o[STAT_DONE_BIT] = done_i;
      end
      OFS_ARG:  rdata_o = arg_q;
      default:  rdata_o = '0;
    endcase
  end

  assign waitrequest_o = read_i && (addr_i == OFS_DATA) && busy_i;
  assign arg_o = arg_q;
endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl #(
  parameter int CNT_W  = 32,
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              step_o,
  output logic              clr_o,
  output logic [MEM_AW-1:0] idx_o
);
  logic [CNT_W-1:0] idx_q, n_q;
  logic             busy_q, done_q, last;

  assign last = (idx_q == n_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      n_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= '0;
      n_q    <= n_i;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign step_o = busy_q && !last;
  assign clr_o  = start_i;
  assign idx_o  = idx_q[MEM_AW-1:0];
endmodule

// File: rtl/dotp_mac.sv
module dotp_mac #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] acc_q, prod;

  assign prod = a_i * b_i; // low DW bits only

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q + prod;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dotp_accel_wrap.sv
module dotp_accel_wrap
  import dotp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              write_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              read_i,
  output logic [DW-1:0]     rdata_o,
  output logic              waitrequest_o,
  output logic [MEM_AW-1:0] a_addr_o,
  input  logic [DW-1:0]     a_rdata_i,
  output logic [MEM_AW-1:0] b_addr_o,
  input  logic [DW-1:0]     b_rdata_i
);
  logic [DW-1:0]     arg, result;
  logic              start, busy, done, step, clr;
  logic [MEM_AW-1:0] idx;

  dotp_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .write_i, .wdata_i, .read_i,
    .busy_i(busy), .done_i(done), .result_i(result),
    .arg_o(arg), .start_o(start), .rdata_o, .waitrequest_o
  );

  dotp_ctrl #(.CNT_W(DW), .MEM_AW(MEM_AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .n_i(arg),
    .busy_o(busy), .done_o(done), .step_o(step), .clr_o(clr), .idx_o(idx)
  );

  dotp_mac #(.DW(DW)) u_mac (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(step),
    .a_i(a_rdata_i), .b_i(b_rdata_i), .acc_o(result)
  );

  assign a_addr_o = idx;
  assign b_addr_o = idx;
endmodule

// File: rtl/dotp_accel_chk.sv
module dotp_accel_chk
  import dotp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MEM_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BUS_AW-1:0] addr_i,
  input logic              write_i,
  input logic [DW-1:0]     wdata_i,
  input logic              read_i,
  input logic [DW-1:0]     rdata_o,
  input logic              waitrequest_o,
  input logic [MEM_AW-1:0] a_addr_o,
  input logic              busy,
  input logic              done,
  input logic [DW-1:0]     arg,
  input logic [DW-1:0]     result
);
  logic go;
  assign go = write_i && addr_i == OFS_STAT && wdata_i == DW'(1) && !busy;

  a_r1_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && addr_i != OFS_DATA && addr_i != OFS_STAT && addr_i != OFS_ARG) |-> rdata_o == '0);

  a_r3_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> (busy && !done));

  a_r5_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done);

  a_r5_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));

  a_r6_wait_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waitrequest_o |-> (busy && read_i && addr_i == OFS_DATA));

  a_r8_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && arg == '0) |=> busy ##1 (!busy && done && result == '0));

  a_r10_first_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> a_addr_o == '0);
endmodule

bind dotp_accel_wrap dotp_accel_chk #(.DW(DW), .MEM_AW(MEM_AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .write_i(write_i),
  .wdata_i(wdata_i), .read_i(read_i), .rdata_o(rdata_o),
  .waitrequest_o(waitrequest_o), .a_addr_o(a_addr_o), .busy(busy),
  .done(done), .arg(arg), .result(result)
);

// File: tb/dotp_accel_wrap_tb.sv
module dotp_accel_wrap_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        write_i = 1'b0, read_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        waitrequest_o;
  logic [7:0]  a_addr_o, b_addr_o;
  logic [31:0] mem_a [256];
  logic [31:0] mem_b [256];
  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  dotp_accel_wrap u_dut (
    .clk_i, .rst_ni, .addr_i, .write_i, .wdata_i, .read_i, .rdata_o,
    .waitrequest_o, .a_addr_o, .a_rdata_i(mem_a[a_addr_o]),
    .b_addr_o, .b_rdata_i(mem_b[b_addr_o])
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dot_ref(int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = s + mem_a[i[7:0]] * mem_b[i[7:0]];
    return s;
  endfunction

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; write_i = 1'b1;
    @(posedge clk_i); #1;
    write_i = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d, output int waits);
    @(negedge clk_i);
    addr_i = a; read_i = 1'b1; #1;
    waits = 0;
    while (waitrequest_o) begin
      @(negedge clk_i); #1; waits++;
    end
    d = rdata_o;
    read_i = 1'b0;
  endtask

  task automatic fill(bit ones);
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = ones ? 32'hFFFF_FFFF : $urandom;
      mem_b[i] = ones ? 32'hFFFF_FFFF : $urandom;
    end
  endtask

  // start then read data with stall; check result and stall length
  task automatic run_len(int n, string tag);
    logic [31:0] d; int w;
    bus_wr(4'hC, n);
    bus_wr(4'h8, 32'd1);
    bus_rd(4'h0, d, w);
    chk({tag, " R4 result"}, d, dot_ref(n));
    chk({tag, " R6 stall cycles"}, w, n + 1);
    bus_rd(4'h8, d, w);
    chk({tag, " R5 status done"}, d, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d; int w, cnt;
    void'($urandom(32'd20240611));
    fill(1'b0);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R9 reset state
    chk("R9 waitreq", {31'b0, waitrequest_o}, 32'h0);
    bus_rd(4'h8, d, w); chk("R9 status", d, 32'h0);
    bus_rd(4'h0, d, w); chk("R9 data", d, 32'h0);
    bus_rd(4'hC, d, w); chk("R9 arg", d, 32'h0);

    // R2 arg readback, R1 unmapped
    bus_wr(4'hC, 32'hDEAD_BEEF);
    bus_rd(4'hC, d, w); chk("R2 arg readback", d, 32'hDEAD_BEEF);
    bus_wr(4'h4, 32'h1234_5678);
    bus_rd(4'h4, d, w); chk("R1 unmapped read", d, 32'h0);
    bus_rd(4'hC, d, w); chk("R1 unmapped write no effect", d, 32'hDEAD_BEEF);
    bus_wr(4'h0, 32'h5555_5555);
    bus_rd(4'h0, d, w); chk("R1 data not writable", d, 32'h0);

    // R3 non-1 status values do not start
    bus_wr(4'hC, 32'd3);
    bus_wr(4'h8, 32'd3);
    bus_rd(4'h8, d, w); chk("R3 value 3 no start", d, 32'h0);
    bus_wr(4'h8, 32'h8000_0001);
    bus_rd(4'h8, d, w); chk("R3 high bit no start", d, 32'h0);

    // R8 N=0
    run_len(0, "R8");
    // R5 N=1 edge
    run_len(1, "R5 n1");

    // R5 busy window by status polling; R3 done cleared on start
    bus_wr(4'hC, 32'd7);
    bus_wr(4'h8, 32'd1);
    cnt = 0;
    bus_rd(4'h8, d, w);
    chk("R3 busy set done clear", d, 32'h1);
    while (d[0]) begin cnt++; bus_rd(4'h8, d, w); end
    chk("R5 busy cycles", cnt, 32'd8);
    chk("R5 end status", d, 32'h2);
    bus_rd(4'h0, d, w); chk("R4 n7 result", d, dot_ref(7));

    // R10 index walk
    bus_wr(4'hC, 32'd5);
    bus_wr(4'h8, 32'd1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R10 a index", {24'b0, a_addr_o}, i);
      chk("R10 b index", {24'b0, b_addr_o}, i);
    end
    bus_rd(4'h0, d, w); chk("R10 run result", d, dot_ref(5));

    // R7 start while busy
    bus_wr(4'hC, 32'd30);
    bus_wr(4'h8, 32'd1);
    bus_wr(4'hC, 32'd4);
    bus_wr(4'h8, 32'd1);
    bus_rd(4'h0, d, w); chk("R7 result of first start", d, dot_ref(30));
    chk("R7 total stall", w, 32'd29);
    bus_rd(4'h8, d, w); chk("R7 no second run", d, 32'h2);
    bus_rd(4'hC, d, w); chk("R7 arg still writable", d, 32'd4);

    // R4 wrap with all-ones operands
    fill(1'b1);
    run_len(3, "R4 wrap");
    run_len(40, "R4 wrap long");

    // random runs
    for (int k = 0; k < 20; k++) begin
      fill(1'b0);
      run_len($urandom_range(1, 40), "R4 rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule